// File: doc/BRIEF.md
# LCD Horizontal Line Timing Generator

This block produces the horizontal timing of one panel line, measured in pixel clocks. Each line opens with an active display region and closes with a non-display (blanking) region. A line pulse for TFT-style panels sits inside the blanking region. A one-cycle end-of-line strobe marks the final blanking pixel, which lets vertical timing logic step from line to line.

The display width, the blanking width, the pulse start and the pulse width are all set in units of 8 pixels. The display and blanking fields give (field + 1) × 8 pixels. A colour-depth select adds a fixed offset to the pulse start. That offset is 4 pixels for 4/8 bpp and 6 pixels for 15/16 bpp. The block captures all settings at reset and again on every end-of-line cycle, so a setting changed during a line first applies to the next line. If a captured setting breaks a timing rule, a sticky error flag rises. The pulse is then cut off at the last blanking pixel.

Top module: `lcd_hline_timer`

## Requirements
- R1: A synchronous reset (`rst` high) places the line at its first active pixel. In the first cycle after reset, `de_o` = 1, `eol_o` = 0 and `cfg_err_o` = 0.
- R2: `de_o` is high for the first (`disp_units` + 1) × 8 cycles of each line. It is low for the (`blank_units` + 1) × 8 cycles that follow.
- R3: A line lasts (`disp_units` + 1 + `blank_units` + 1) × 8 cycles, and lines follow one another with no gap.
- R4: The pulse starts `lp_start` × 8 + 4 pixels after the first blanking pixel when `deep_color` = 0 (4/8 bpp). It starts `lp_start` × 8 + 6 pixels after that pixel when `deep_color` = 1 (15/16 bpp).
- R5: The pulse lasts (`lp_width` + 1) × 8 pixels. It drives `lp_o` low when `lp_high` = 0 and high when `lp_high` = 1. Otherwise `lp_o` holds the opposite level. The pulse never extends past the last blanking pixel. If the pulse would start after that pixel, no pulse appears.
- R6: `eol_o` is high for exactly one cycle, on the last blanking pixel of each line.
- R7: All setting inputs, including `deep_color` and `lp_high`, are captured during reset and on the cycle where `eol_o` is high. Changes made in any other cycle have no effect until the next line.
- R8: `cfg_err_o` rises one cycle after a line begins with captured settings that break a rule. The rules are `blank_units` + 1 ≥ (`lp_start` + 1) + (`lp_width` + 1), and `disp_units` ≥ 3. The flag then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| disp_units | input | 7 | Active width field, (n+1)×8 pixels |
| blank_units | input | 5 | Blanking width field, (n+1)×8 pixels |
| lp_start | input | 5 | Pulse start field, 8-pixel units |
| lp_width | input | 4 | Pulse width field, (n+1)×8 pixels |
| deep_color | input | 1 | 0: 4/8 bpp (+4 offset), 1: 15/16 bpp (+6 offset) |
| lp_high | input | 1 | Pulse polarity, 0 active-low, 1 active-high |
| de_o | output | 1 | Display enable |
| lp_o | output | 1 | Line pulse |
| eol_o | output | 1 | End-of-line strobe |
| cfg_err_o | output | 1 | Sticky configuration error |

## Verification
`de_o`, `lp_o` and `eol_o` are decoded directly from registered state, so each reflects the pixel position and captured settings in the same cycle, with zero added latency. `cfg_err_o` comes one register later, so it follows a violating capture by exactly one cycle. The bench keeps its own line position and its own capture of the settings. It advances both at each rising edge, using the values that were on the inputs before that edge. It then compares all four outputs at the falling edge of every cycle, so every check samples only after every register feeding it has updated.

// File: rtl/lcd_hl_pkg.sv
package lcd_hl_pkg;

   typedef enum logic {
      PH_ACT   = 1'b0,
      PH_BLANK = 1'b1
   } hl_phase_e;

endpackage

// File: rtl/hl_cfg_latch.sv
module hl_cfg_latch #(
   parameter int DISP_W   = 7,
   parameter int ND_W     = 5,
   parameter int ST_W     = 5,
   parameter int PW_W     = 4,
   parameter int MIN_DISP = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [DISP_W-1:0] disp_in,
   input  logic [ND_W-1:0]   nd_in,
   input  logic [ST_W-1:0]   st_in,
   input  logic [PW_W-1:0]   pw_in,
   input  logic              deep_in,
   input  logic              pol_in,
   output logic [DISP_W-1:0] disp_sh,
   output logic [ND_W-1:0]   nd_sh,
   output logic [ST_W-1:0]   st_sh,
   output logic [PW_W-1:0]   pw_sh,
   output logic              deep_sh,
   output logic              pol_sh,
   output logic              err
);
   localparam int SUM_W = ((ND_W > ST_W) ? ND_W : ST_W) + 2;

   logic viol;
   logic [SUM_W-1:0] need_units;

   initial begin
      assert (MIN_DISP < (1 << DISP_W)) else $fatal(1, "MIN_DISP exceeds display field");
      assert (PW_W <= ND_W) else $fatal(1, "pulse width field wider than blanking field");
   end

   always_ff @(posedge clk) begin
      if (load) begin
         disp_sh <= disp_in;
         nd_sh   <= nd_in;
         st_sh   <= st_in;
         pw_sh   <= pw_in;
         deep_sh <= deep_in;
         pol_sh  <= pol_in;
      end
   end

   always_comb begin
      need_units = SUM_W'(st_sh) + SUM_W'(pw_sh) + SUM_W'(1);
      viol = (SUM_W'(nd_sh) < need_units) || (disp_sh < DISP_W'(MIN_DISP));
   end

   always_ff @(posedge clk) begin
      if (rst)       err <= 1'b0;
      else if (viol) err <= 1'b1;
   end

   a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst) err |=> err);

endmodule

// File: rtl/hl_line_cnt.sv
module hl_line_cnt
   import lcd_hl_pkg::*;
#(
   parameter int DISP_W  = 7,
   parameter int ND_W    = 5,
   parameter int UNIT_LG = 3,
   parameter int CNT_W   = 10
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DISP_W-1:0] disp_sh,
   input  logic [ND_W-1:0]   nd_sh,
   output hl_phase_e         phase,
   output logic [CNT_W-1:0]  cnt,
   output logic              line_end
);
   localparam int LW = CNT_W + 1;

   logic [LW-1:0] act_last, nd_last;
   logic          phase_end;

   always_comb begin
      act_last  = (LW'(disp_sh) + LW'(1)) * LW'(1 << UNIT_LG) - LW'(1);
      nd_last   = (LW'(nd_sh)   + LW'(1)) * LW'(1 << UNIT_LG) - LW'(1);
      phase_end = (LW'(cnt) == ((phase == PH_ACT) ? act_last : nd_last));
      line_end  = (phase == PH_BLANK) && phase_end;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         phase <= PH_ACT;
         cnt   <= '0;
      end else if (phase_end) begin
         phase <= (phase == PH_ACT) ? PH_BLANK : PH_ACT;
         cnt   <= '0;
      end else begin
         cnt   <= cnt + CNT_W'(1);
      end
   end

   a_r2_active_after_end: assert property (@(posedge clk) disable iff (rst)
      line_end |=> (phase == PH_ACT) && (cnt == '0));
   a_r6_end_in_blank: assert property (@(posedge clk) disable iff (rst)
      line_end |-> $past(phase == PH_BLANK) || $past(rst));

endmodule

// File: rtl/hl_pulse_win.sv
module hl_pulse_win
   import lcd_hl_pkg::*;
#(
   parameter int ND_W      = 5,
   parameter int ST_W      = 5,
   parameter int PW_W      = 4,
   parameter int UNIT_LG   = 3,
   parameter int CNT_W     = 10,
   parameter int OFS_LO    = 4,
   parameter int OFS_HI    = 6,
   parameter bit CLAMP_END = 1'b1
) (
   input  hl_phase_e        phase,
   input  logic [CNT_W-1:0] cnt,
   input  logic [ND_W-1:0]  nd_sh,
   input  logic [ST_W-1:0]  st_sh,
   input  logic [PW_W-1:0]  pw_sh,
   input  logic             deep_sh,
   input  logic             pol_sh,
   output logic             lp
);
   localparam int W = CNT_W + 3;

   logic [W-1:0] start_px, end_raw, nd_last, end_px;
   logic         active;

   initial begin
      assert (OFS_LO < (1 << UNIT_LG) && OFS_HI < (1 << UNIT_LG))
         else $fatal(1, "pulse offset must stay below one unit");
   end

   always_comb begin
      start_px = (W'(st_sh) << UNIT_LG) + (deep_sh ? W'(OFS_HI) : W'(OFS_LO));
      end_raw  = start_px + ((W'(pw_sh) + W'(1)) << UNIT_LG) - W'(1);
      nd_last  = ((W'(nd_sh) + W'(1)) << UNIT_LG) - W'(1);
   end

   generate
      if (CLAMP_END) begin : g_clamp
         assign end_px = (end_raw > nd_last) ? nd_last : end_raw;
      end else begin : g_raw
         assign end_px = end_raw;
      end
   endgenerate

   always_comb begin
      active = (phase == PH_BLANK) && (W'(cnt) >= start_px) && (W'(cnt) <= end_px);
      lp     = pol_sh ? active : ~active;
   end

endmodule

// File: rtl/lcd_hline_timer.sv
module lcd_hline_timer
   import lcd_hl_pkg::*;
#(
   parameter int DISP_W   = 7,
   parameter int ND_W     = 5,
   parameter int ST_W     = 5,
   parameter int PW_W     = 4,
   parameter int UNIT_LG  = 3,
   parameter int OFS_LO   = 4,
   parameter int OFS_HI   = 6,
   parameter int MIN_DISP = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DISP_W-1:0] disp_units,
   input  logic [ND_W-1:0]   blank_units,
   input  logic [ST_W-1:0]   lp_start,
   input  logic [PW_W-1:0]   lp_width,
   input  logic              deep_color,
   input  logic              lp_high,
   output logic              de_o,
   output logic              lp_o,
   output logic              eol_o,
   output logic              cfg_err_o
);
   localparam int WIDE_W = (DISP_W > ND_W) ? DISP_W : ND_W;
   localparam int CNT_W  = WIDE_W + UNIT_LG;

   initial begin
      assert (UNIT_LG >= 1) else $fatal(1, "UNIT_LG must be at least 1");
      assert (ST_W <= ND_W) else $fatal(1, "start field wider than blanking field");
   end

   logic [DISP_W-1:0] disp_sh;
   logic [ND_W-1:0]   nd_sh;
   logic [ST_W-1:0]   st_sh;
   logic [PW_W-1:0]   pw_sh;
   logic              deep_sh, pol_sh;
   hl_phase_e         phase;
   logic [CNT_W-1:0]  cnt;
   logic              line_end;

   hl_cfg_latch #(
      .DISP_W(DISP_W), .ND_W(ND_W), .ST_W(ST_W), .PW_W(PW_W), .MIN_DISP(MIN_DISP)
   ) u_cfg (
      .clk(clk), .rst(rst), .load(rst | line_end),
      .disp_in(disp_units), .nd_in(blank_units), .st_in(lp_start), .pw_in(lp_width),
      .deep_in(deep_color), .pol_in(lp_high),
      .disp_sh(disp_sh), .nd_sh(nd_sh), .st_sh(st_sh), .pw_sh(pw_sh),
      .deep_sh(deep_sh), .pol_sh(pol_sh), .err(cfg_err_o)
   );

   hl_line_cnt #(
      .DISP_W(DISP_W), .ND_W(ND_W), .UNIT_LG(UNIT_LG), .CNT_W(CNT_W)
   ) u_cnt (
      .clk(clk), .rst(rst), .disp_sh(disp_sh), .nd_sh(nd_sh),
      .phase(phase), .cnt(cnt), .line_end(line_end)
   );

   hl_pulse_win #(
      .ND_W(ND_W), .ST_W(ST_W), .PW_W(PW_W), .UNIT_LG(UNIT_LG), .CNT_W(CNT_W),
      .OFS_LO(OFS_LO), .OFS_HI(OFS_HI), .CLAMP_END(1'b1)
   ) u_lp (
      .phase(phase), .cnt(cnt), .nd_sh(nd_sh), .st_sh(st_sh), .pw_sh(pw_sh),
      .deep_sh(deep_sh), .pol_sh(pol_sh), .lp(lp_o)
   );

   assign de_o  = (phase == PH_ACT);
   assign eol_o = line_end;

   a_r1_reset_start: assert property (@(posedge clk) rst |=> de_o && !eol_o && !cfg_err_o);
   a_r6_eol_single: assert property (@(posedge clk) disable iff (rst) eol_o |=> !eol_o);
   a_r6_eol_not_de: assert property (@(posedge clk) disable iff (rst) eol_o |-> !de_o);
   a_r5_pulse_in_blank: assert property (@(posedge clk) disable iff (rst)
      (lp_o == pol_sh) |-> !de_o);
   a_r7_hold_midline: assert property (@(posedge clk) disable iff (rst)
      !$past(eol_o) && !$past(rst) |-> $stable(nd_sh) && $stable(pol_sh));

endmodule

// File: tb/sim_lcd_hline_timer.sv
module sim_lcd_hline_timer;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [6:0] disp_units = 7'd3;
   logic [4:0] blank_units = 5'd3;
   logic [4:0] lp_start = 5'd0;
   logic [3:0] lp_width = 4'd0;
   logic       deep_color = 1'b0;
   logic       lp_high = 1'b0;
   logic       de_o, lp_o, eol_o, cfg_err_o;

   int checks = 0;
   int errors = 0;
   bit chk_en = 1'b0;
   string ctx = "";

   // bench model state
   int mpos = 0;
   int sd = 3, sn = 3, ss = 0, sw = 0;
   bit sdeep = 0, spol = 0, merr = 0;

   always #2.5 clk = ~clk;

   lcd_hline_timer u0 (
      .clk(clk), .rst(rst), .disp_units(disp_units), .blank_units(blank_units),
      .lp_start(lp_start), .lp_width(lp_width), .deep_color(deep_color),
      .lp_high(lp_high), .de_o(de_o), .lp_o(lp_o), .eol_o(eol_o), .cfg_err_o(cfg_err_o)
   );

   function automatic bit viol(int d, int n, int s, int w);
      return (n + 1 < (s + 1) + (w + 1)) || (d < 3);
   endfunction

   task automatic cmp(string req, logic got, logic exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s pos=%0d got %b expected %b", req, ctx, mpos, got, exp);
      end
   endtask

   task automatic check_all();
      int la, ln, q, st, en;
      bit act, e_de, e_eol;
      la = (sd + 1) * 8;
      ln = (sn + 1) * 8;
      e_de = mpos < la;
      q = mpos - la;
      st = ss * 8 + (sdeep ? 6 : 4);
      en = st + (sw + 1) * 8 - 1;
      if (en > ln - 1) en = ln - 1;
      act = !e_de && q >= st && q <= en;
      e_eol = !e_de && q == ln - 1;
      cmp("R2 R3 de", de_o, e_de);
      cmp("R4 R5 lp", lp_o, spol ? act : !act);
      cmp("R6 eol", eol_o, e_eol);
      cmp("R8 err", cfg_err_o, merr);
   endtask

   // advance model with current inputs, clock, then check at falling edge
   task automatic tick();
      int ltot;
      ltot = (sd + 1 + sn + 1) * 8;
      @(posedge clk);
      if (rst) begin
         mpos = 0; merr = 0;
         sd = disp_units; sn = blank_units; ss = lp_start; sw = lp_width;
         sdeep = deep_color; spol = lp_high;
      end else begin
         if (viol(sd, sn, ss, sw)) merr = 1;
         if (mpos == ltot - 1) begin
            mpos = 0;
            sd = disp_units; sn = blank_units; ss = lp_start; sw = lp_width;
            sdeep = deep_color; spol = lp_high;
         end else mpos++;
      end
      @(negedge clk);
      if (chk_en) check_all();
   endtask

   task automatic set_cfg(int d, int n, int s, int w, bit dp, bit pl);
      disp_units = 7'(d); blank_units = 5'(n); lp_start = 5'(s);
      lp_width = 4'(w); deep_color = dp; lp_high = pl;
   endtask

   task automatic do_reset();
      rst = 1'b1;
      tick(); tick();
      rst = 1'b0;
   endtask

   initial begin
      #950000;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int nds[5] = '{0, 2, 5, 9, 31};
      int sts[4] = '{0, 1, 4, 31};
      int pws[3] = '{0, 3, 15};
      int idx = 0;
      int ltot;
      @(negedge clk);
      tick();
      chk_en = 1'b1;

      // R1: reset state
      set_cfg(3, 5, 1, 1, 0, 0);
      do_reset();
      tick();
      ctx = "R1";
      cmp("R1 de", de_o, 1'b1);
      cmp("R1 eol", eol_o, 1'b0);
      cmp("R1 err", cfg_err_o, 1'b0);

      // sweep of settings (R2 R3 R4 R5 R6 R8)
      ctx = "sweep";
      foreach (nds[a]) foreach (sts[b]) foreach (pws[c])
         for (int dp = 0; dp < 2; dp++) for (int pl = 0; pl < 2; pl++) begin
            set_cfg(2 + (idx % 4), nds[a], sts[b], pws[c], dp[0], pl[0]);
            idx++;
            do_reset();
            ltot = (sd + 1 + sn + 1) * 8;
            for (int k = 0; k < ltot + 3; k++) tick();
         end

      // R7: change in mid-line applies at the next line only
      ctx = "R7";
      set_cfg(3, 5, 1, 1, 0, 0);
      do_reset();
      for (int k = 0; k < 10; k++) tick();
      set_cfg(4, 9, 2, 3, 1, 1);
      for (int k = 0; k < 600; k++) tick();
      cmp("R7 new pol", spol, 1'b1);

      // R8: error stays after settings become valid again
      ctx = "R8";
      set_cfg(3, 0, 0, 0, 0, 0);
      do_reset();
      tick();
      set_cfg(3, 9, 1, 1, 1, 0);
      for (int k = 0; k < 400; k++) tick();
      cmp("R8 sticky", cfg_err_o, 1'b1);
      rst = 1'b1; tick(); rst = 1'b0; tick();
      cmp("R8 cleared by reset", cfg_err_o, 1'b0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule